// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmitter

This block sends words one bit at a time on a serial data line, least significant bit first, framed by a serial clock. It has two storage stages. Software writes a word into a holding buffer. The block moves that word into a shift register as soon as the line is free. The buffer can then take the next word while the current frame is still shifting. If the buffer is full when a frame ends, the next frame follows with no idle gap. When the last bit leaves and no further word is waiting, a sticky transmit-end flag is set.

In master mode the block produces the serial clock from a programmable divider of the system clock. In slave mode it leaves the clock pin undriven. It then follows an external clock, which passes through a synchronizer and an edge detector. Software sets the frame length (8 to 16 bits), the clock rest level and the clock phase. Two interrupt requests are available: buffer empty and transmit end. An overrun flag comes in from the receive side, and while it is set no frame may start.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, buf_empty is 1, tend is 0, sdo is 0, sck_out equals cpol and irq_tend is 0.
- R2: A write pulse (wr_en) while tx_en is 1 captures wr_data and drives buf_empty to 0 on the next cycle. A write while tx_en is 0 is ignored: buf_empty stays 1 and no frame is sent, even after tx_en is raised again.
- R3: A full buffer is moved into the shift register when the line is idle, tx_en is 1 and ovr_in is 0. buf_empty then returns to 1 one cycle later. irq_txe is buf_empty gated by txe_ie.
- R4: The frame length comes from len_code. A value of 8 to 15 gives that many bits. 0 gives 16 bits. Codes 1 to 7 give 8 bits. Data bits above the frame length are not sent.
- R5: Bits go out least significant first. With cpha 0, each bit is on sdo before the first clock edge of its bit period and changes on the second edge. With cpha 1, each bit changes on the first edge and is stable on the second edge.
- R6: In master mode sck_oe is 1. Each half period of sck_out lasts half_div+1 system clocks. Between frames sck_out rests at cpol.
- R7: If the buffer is full when the last clock edge of a frame occurs, the next frame starts without an extra half period: every edge of a chained burst is half_div+1 cycles after the previous one.
- R8: tend is set when the last edge of a frame occurs while buf_empty is 1. It stays set until cleared. irq_tend is tend gated by tend_ie. tend is not set at the end of a frame that is followed by a chained frame.
- R9: tend is cleared by a buffer write or by a clr_tend pulse. When a write falls in the same cycle as the last edge of a frame with an empty buffer, the write wins: tend stays 0 and the new frame starts one cycle later than a chained frame would.
- R10: While ovr_in is 1 no frame starts, whether from idle or chained at the end of a frame. A waiting word is sent once ovr_in returns to 0.
- R11: In slave mode sck_oe is 0. Both edges of sck_in, seen after a two-flop synchronizer, advance the frame with the same bit order and phase rules as in master mode.
- R12: Dropping tx_en aborts any frame, sets buf_empty to 1, clears tend and returns sck_out to cpol on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| master | input | 1 | 1 drives the serial clock, 0 follows sck_in |
| cpol | input | 1 | Serial clock rest level |
| cpha | input | 1 | Clock phase select |
| len_code | input | 4 | Frame length code |
| half_div | input | DIV_W (8) | Master half period minus one, in system clocks |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 16 | Word to transmit |
| clr_tend | input | 1 | Clear transmit-end flag |
| txe_ie | input | 1 | Buffer-empty interrupt enable |
| tend_ie | input | 1 | Transmit-end interrupt enable |
| ovr_in | input | 1 | Overrun flag from the receive side |
| sck_in | input | 1 | External serial clock in slave mode |
| sck_out | output | 1 | Serial clock output |
| sck_oe | output | 1 | Serial clock output enable |
| sdo | output | 1 | Serial data output |
| buf_empty | output | 1 | Holding buffer empty |
| tend | output | 1 | Transmit-end flag |
| irq_txe | output | 1 | Buffer-empty interrupt request |
| irq_tend | output | 1 | Transmit-end interrupt request |

## Verification
The interesting overlap is a buffer write that lands in the same clock as the final edge of a frame sent with an empty buffer. The set of the end flag and the clear caused by the write then coincide. The bench counts the serial clock transitions at the ports and issues the write exactly half_div cycles after it sees the next-to-last edge. It then judges the result in two ways: tend must never be seen high, and the gap to the next frame's first edge must be one cycle longer than the gap of a chained frame. The second test shows that the write really fell into the frame-end cycle.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  localparam int unsigned MAX_BITS = 16;
  localparam int unsigned NB_W     = $clog2(MAX_BITS + 1);
  localparam int unsigned EC_W     = NB_W + 1;

  // frame length decode: 8..15 literal, 0 -> 16, others -> 8
  function automatic logic [NB_W-1:0] frame_bits(input logic [3:0] code);
    if (code == 4'd0) return NB_W'(MAX_BITS);
    else if (code[3]) return NB_W'(code);
    else return NB_W'(8);
  endfunction
endpackage

// File: rtl/ssx_edgegen.sv
module ssx_edgegen #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             master,
  input  logic             busy,
  input  logic [DIV_W-1:0] half_div,
  input  logic             sck_in,
  output logic             edge_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick;
  logic [SYNC_N:0]  sync_q, sync_d;
  logic             ext_edge;

  // master divider: one tick per half period while a frame runs
  always_comb begin
    cnt_d = cnt_q;
    tick  = 1'b0;
    if (!(en && master && busy)) begin
      cnt_d = '0;
    end else if (cnt_q == half_div) begin
      cnt_d = '0;
      tick  = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  // slave path: synchronizer stages plus one history stage
  always_comb begin
    sync_d = {sync_q[SYNC_N-1:0], sck_in};
  end

  assign ext_edge = sync_q[SYNC_N] ^ sync_q[SYNC_N-1];
  assign edge_o   = master ? tick : (en && busy && ext_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
    end
  end
endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter
  import ssx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                cpha,
  input  logic [NB_W-1:0]     nbits,
  input  logic                load,
  input  logic [MAX_BITS-1:0] ld_data,
  input  logic                edge_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                lvl_o,
  output logic                sdo_o
);
  logic                busy_q, busy_d;
  logic [EC_W-1:0]     ecnt_q, ecnt_d;
  logic                lvl_q, lvl_d;
  logic                sdo_q, sdo_d;
  logic [MAX_BITS-1:0] sreg_q, sreg_d;
  logic [EC_W-1:0]     last_e;
  logic                step, emit, done;

  assign last_e = {nbits, 1'b0} - EC_W'(1);
  assign step   = busy_q && edge_i;
  assign done   = step && (ecnt_q == last_e);
  // cpha 1: new bit on every even edge; cpha 0: on odd edges except the last
  assign emit   = step && (cpha ? !ecnt_q[0] : (ecnt_q[0] && (ecnt_q != last_e)));

  always_comb begin
    busy_d = busy_q;
    ecnt_d = ecnt_q;
    lvl_d  = lvl_q;
    sdo_d  = sdo_q;
    sreg_d = sreg_q;
    if (!en) begin
      busy_d = 1'b0;
      ecnt_d = '0;
      lvl_d  = 1'b0;
    end else if (load) begin
      busy_d = 1'b1;
      ecnt_d = '0;
      lvl_d  = 1'b0;
      sreg_d = cpha ? ld_data : (ld_data >> 1);
      sdo_d  = cpha ? sdo_q : ld_data[0];
    end else if (step) begin
      ecnt_d = done ? '0 : ecnt_q + 1'b1;
      lvl_d  = !lvl_q;
      if (done) busy_d = 1'b0;
      if (emit) begin
        sdo_d  = sreg_q[0];
        sreg_d = sreg_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ecnt_q <= '0;
      lvl_q  <= 1'b0;
      sdo_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ecnt_q <= ecnt_d;
      lvl_q  <= lvl_d;
      sdo_q  <= sdo_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load || emit) sreg_q <= sreg_d;
  end

  assign busy_o = busy_q;
  assign done_o = done;
  assign lvl_o  = lvl_q;
  assign sdo_o  = sdo_q;

  // R7: the buffer controller only loads into a free or finishing shifter
  assert_load_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!busy_q || done));
  // R6: the clock level has returned to rest whenever no frame runs
  assert_rest_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !lvl_q);
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import ssx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_en,
  input  logic                master,
  input  logic                cpol,
  input  logic                cpha,
  input  logic [3:0]          len_code,
  input  logic [DIV_W-1:0]    half_div,
  input  logic                wr_en,
  input  logic [MAX_BITS-1:0] wr_data,
  input  logic                clr_tend,
  input  logic                txe_ie,
  input  logic                tend_ie,
  input  logic                ovr_in,
  input  logic                sck_in,
  output logic                sck_out,
  output logic                sck_oe,
  output logic                sdo,
  output logic                buf_empty,
  output logic                tend,
  output logic                irq_txe,
  output logic                irq_tend
);
  localparam int unsigned SYNC_N = 2;

  logic [1:0]          rs_q;
  logic                rst_sn;
  logic [MAX_BITS-1:0] buf_q;
  logic                buf_we;
  logic                empty_q, empty_d;
  logic                tend_q, tend_d;
  logic [NB_W-1:0]     nbits;
  logic                busy, done, lvl, edge_p, load;

  // reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  assign nbits  = frame_bits(len_code);
  assign buf_we = tx_en && wr_en;
  assign load   = tx_en && !ovr_in && !empty_q && (!busy || done);

  always_comb begin
    empty_d = empty_q;
    tend_d  = tend_q;
    if (!tx_en) begin
      empty_d = 1'b1;
      tend_d  = 1'b0;
    end else begin
      if (wr_en)     empty_d = 1'b0;
      else if (load) empty_d = 1'b1;
      if (wr_en || clr_tend)      tend_d = 1'b0;
      else if (done && empty_q)   tend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      empty_q <= 1'b1;
      tend_q  <= 1'b0;
    end else begin
      empty_q <= empty_d;
      tend_q  <= tend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) buf_q <= wr_data;
  end

  ssx_edgegen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_edge (
    .clk      (clk),
    .rst_n    (rst_sn),
    .en       (tx_en),
    .master   (master),
    .busy     (busy),
    .half_div (half_div),
    .sck_in   (sck_in),
    .edge_o   (edge_p)
  );

  ssx_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_sn),
    .en      (tx_en),
    .cpha    (cpha),
    .nbits   (nbits),
    .load    (load),
    .ld_data (buf_q),
    .edge_i  (edge_p),
    .busy_o  (busy),
    .done_o  (done),
    .lvl_o   (lvl),
    .sdo_o   (sdo)
  );

  assign sck_out   = cpol ^ (master & lvl);
  assign sck_oe    = master;
  assign buf_empty = empty_q;
  assign tend      = tend_q;
  assign irq_txe   = empty_q & txe_ie;
  assign irq_tend  = tend_q & tend_ie;

  assert_tend_rise_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(tend_q) |-> $past(empty_q));
  assert_overrun_hold_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (ovr_in && !busy) |=> !busy);
  assert_disable_clears_R12: assert property (@(posedge clk) disable iff (!rst_sn)
    !tx_en |=> (empty_q && !tend_q && !busy));
  assert_idle_clock_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    !busy |-> (sck_out == cpol));
  assert_load_empties_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (load && !wr_en) |=> empty_q);
  assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && tx_en) |=> (!tend_q && !empty_q));
endmodule

// File: tb/sync_ser_tx_tb.sv
module sync_ser_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, master = 1'b1, cpol = 1'b0, cpha = 1'b0;
  logic [3:0] len_code = 4'd8;
  logic [7:0] half_div = 8'd0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic clr_tend = 1'b0, txe_ie = 1'b1, tend_ie = 1'b1, ovr_in = 1'b0, sck_in = 1'b0;
  logic sck_out, sck_oe, sdo, buf_empty, tend, irq_txe, irq_tend;

  int checks = 0, errors = 0, wd = 0;
  // monitor state
  int cyc = 0, last_tr = 0, last_gap = 0, gap_bad = 0, tr_cnt = 0, ecount = 0;
  int rx_n = 0, tend_early = 0, cfg_n = 8, hp_exp = 1;
  bit mon_on = 0, have_prev = 0, gap_chk = 0, cfg_cpha = 0, tend_seen = 0;
  logic sck_prev = 1'b0;
  logic [15:0] rx_cur = '0;
  logic [15:0] rx_frm [0:3];

  always #2 clk = ~clk;

  sync_ser_tx #(.DIV_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .master(master), .cpol(cpol),
    .cpha(cpha), .len_code(len_code), .half_div(half_div), .wr_en(wr_en),
    .wr_data(wr_data), .clr_tend(clr_tend), .txe_ie(txe_ie), .tend_ie(tend_ie),
    .ovr_in(ovr_in), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .sdo(sdo), .buf_empty(buf_empty), .tend(tend), .irq_txe(irq_txe),
    .irq_tend(irq_tend));

  always @(negedge clk) begin
    cyc++;
    if (mon_on && (sck_out !== sck_prev)) begin
      last_gap = cyc - last_tr;
      if (have_prev && gap_chk && last_gap != hp_exp) gap_bad++;
      last_tr = cyc;
      have_prev = 1;
      if (cfg_cpha ? (ecount % 2 == 1) : (ecount % 2 == 0)) rx_cur[ecount / 2] = sdo;
      ecount++;
      tr_cnt++;
      if (ecount == 2 * cfg_n) begin
        if (rx_n == 0 && tend) tend_early++;
        if (rx_n < 4) rx_frm[rx_n] = rx_cur;
        rx_n++;
        rx_cur = '0;
        ecount = 0;
      end
    end
    if (mon_on && tend) tend_seen = 1;
    sck_prev = sck_out;
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    step();
    wr_en = 1'b1;
    wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_tend(input int lim);
    for (int i = 0; i < lim && !tend; i++) step();
  endtask

  task automatic wait_tr(input int n);
    for (int i = 0; i < 4000 && tr_cnt < n; i++) step();
  endtask

  function automatic int bits_of(input int code);
    if (code == 0) return 16;
    if (code >= 8) return code;
    return 8;
  endfunction

  function automatic logic [15:0] mask_of(input int n);
    return (n == 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  task automatic setup_master(input int code, input bit pol, input bit ph, input int hd);
    mon_on = 0;
    tx_en = 1'b0;
    master = 1'b1;
    cpol = pol;
    cpha = ph;
    len_code = 4'(code);
    half_div = 8'(hd);
    step();
    tx_en = 1'b1;
    cfg_n = bits_of(code);
    cfg_cpha = ph;
    hp_exp = hd + 1;
    ecount = 0; rx_n = 0; have_prev = 0; tr_cnt = 0; tend_seen = 0;
    tend_early = 0; gap_bad = 0; rx_cur = '0;
    step();
    mon_on = 1;
  endtask

  task automatic run_slave(input int code, input bit pol, input bit ph, input logic [15:0] d);
    int n;
    logic [15:0] rx;
    mon_on = 0;
    tx_en = 1'b0;
    master = 1'b0;
    cpol = pol;
    cpha = ph;
    len_code = 4'(code);
    sck_in = pol;
    repeat (4) step();
    tx_en = 1'b1;
    step();
    wr(d);
    repeat (4) step();
    n = bits_of(code);
    rx = '0;
    for (int i = 0; i < 2 * n; i++) begin
      repeat (8) step();
      if (ph ? (i % 2 == 1) : (i % 2 == 0)) rx[i / 2] = sdo;
      sck_in = ~sck_in;
    end
    repeat (8) step();
    chk(sck_oe == 1'b0, "R11", "slave sck_oe", sck_oe, 0);
    chk(rx == (d & mask_of(n)), "R11", "slave frame", rx, d & mask_of(n));
    chk(tend == 1'b1, "R11", "slave tend", tend, 1);
  endtask

  initial begin
    logic [15:0] d0, d1;
    int code, hd, n, snap;
    repeat (3) step();
    // R1 reset state
    chk(buf_empty == 1'b1 && tend == 1'b0, "R1", "flags after reset", {buf_empty, tend}, 2);
    chk(sdo == 1'b0 && sck_out == 1'b0 && irq_tend == 1'b0, "R1", "outputs after reset",
        {sdo, sck_out, irq_tend}, 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk(buf_empty == 1'b1 && tend == 1'b0 && sdo == 1'b0, "R1", "state after release",
        {buf_empty, tend, sdo}, 4);

    // R2 write ignored while disabled
    setup_master(8, 1'b0, 1'b0, 1);
    tx_en = 1'b0;
    wr(16'h1234);
    repeat (30) step();
    chk(buf_empty == 1'b1 && tr_cnt == 0, "R2", "write while disabled", tr_cnt, 0);
    tx_en = 1'b1;
    repeat (30) step();
    chk(buf_empty == 1'b1 && tr_cnt == 0, "R2", "nothing latent after enable", tr_cnt, 0);

    // R4 R5 R6 R7 R8 sweep over lengths, polarity, phase and divider
    for (int c = 0; c < 10; c++)
      for (int p = 0; p < 2; p++)
        for (int h = 0; h < 2; h++)
          for (int k = 0; k < 2; k++) begin
            code = (c < 8) ? 8 + c : ((c == 8) ? 0 : 3);
            hd = k ? 2 : 0;
            n = bits_of(code);
            d0 = 16'h6A5C ^ 16'((c * 8 + p * 4 + h * 2 + k) * 16'h01F3);
            d1 = {d0[7:0], d0[15:8]} ^ 16'h8001;
            setup_master(code, p[0], h[0], hd);
            gap_chk = 1;
            wr(d0);
            chk(buf_empty == 1'b0, "R2", "buffer full after write", buf_empty, 0);
            step();
            chk(buf_empty == 1'b1, "R3", "buffer moved to shifter", buf_empty, 1);
            wr(d1);
            wait_tend(4000);
            repeat (2) step();
            chk(rx_n == 2 && tr_cnt == 4 * n, "R4", "edge count", tr_cnt, 4 * n);
            chk(rx_frm[0] == (d0 & mask_of(n)), "R5", "first frame", rx_frm[0], d0 & mask_of(n));
            chk(rx_frm[1] == (d1 & mask_of(n)), "R5", "second frame", rx_frm[1], d1 & mask_of(n));
            chk(gap_bad == 0, "R7", "gapless half periods", gap_bad, 0);
            chk(tend_early == 0 && tend == 1'b1, "R8", "tend only after last frame",
                {tend_early[0], tend}, 1);
            chk(sck_out == p[0] && sck_oe == 1'b1, "R6", "clock rest level", sck_out, p);
            gap_chk = 0;
          end

    // R3 R8 interrupt gating and stickiness (tend and buf_empty are 1 here)
    txe_ie = 1'b0; tend_ie = 1'b0;
    step();
    chk(irq_txe == 1'b0 && irq_tend == 1'b0, "R3", "irqs masked", {irq_txe, irq_tend}, 0);
    txe_ie = 1'b1; tend_ie = 1'b1;
    step();
    chk(irq_txe == 1'b1 && irq_tend == 1'b1, "R8", "irqs raised", {irq_txe, irq_tend}, 3);
    repeat (50) step();
    chk(tend == 1'b1, "R8", "tend sticky", tend, 1);
    clr_tend = 1'b1;
    step();
    clr_tend = 1'b0;
    chk(tend == 1'b0 && irq_tend == 1'b0, "R9", "clear by clr_tend", tend, 0);

    // R9 clear by a write
    setup_master(8, 1'b0, 1'b0, 1);
    wr(16'h00F0);
    wait_tend(2000);
    chk(tend == 1'b1, "R8", "tend set", tend, 1);
    wr(16'h0033);
    chk(tend == 1'b0, "R9", "clear by write", tend, 0);
    wait_tend(2000);

    // R9 write collides with the frame-end cycle
    setup_master(8, 1'b0, 1'b0, 2);
    wr(16'h00A7);
    wait_tr(15);
    repeat (2) step();
    wr_en = 1'b1;
    wr_data = 16'h005E;
    step();
    wr_en = 1'b0;
    wait_tr(17);
    chk(last_gap == 4, "R9", "restart gap after collision", last_gap, 4);
    chk(tend_seen == 1'b0, "R9", "tend never set on collision", tend_seen, 0);
    wait_tend(2000);
    repeat (2) step();
    chk(rx_n == 2 && rx_frm[1] == 16'h005E, "R9", "collided word sent", rx_frm[1], 16'h005E);

    // R10 overrun blocks a start from idle
    setup_master(8, 1'b1, 1'b1, 1);
    ovr_in = 1'b1;
    wr(16'h00C3);
    repeat (40) step();
    chk(tr_cnt == 0 && buf_empty == 1'b0, "R10", "no start under overrun", tr_cnt, 0);
    ovr_in = 1'b0;
    wait_tend(2000);
    repeat (2) step();
    chk(rx_n == 1 && rx_frm[0] == 16'h00C3, "R10", "sent after clear", rx_frm[0], 16'h00C3);

    // R10 overrun blocks a chained start
    setup_master(8, 1'b0, 1'b0, 1);
    wr(16'h0081);
    step();
    wr(16'h0042);
    wait_tr(4);
    ovr_in = 1'b1;
    repeat (80) step();
    chk(rx_n == 1 && tr_cnt == 16, "R10", "chain held", tr_cnt, 16);
    chk(tend == 1'b0 && buf_empty == 1'b0, "R10", "flags while held", {tend, buf_empty}, 0);
    ovr_in = 1'b0;
    wait_tend(2000);
    repeat (2) step();
    chk(rx_n == 2 && rx_frm[1] == 16'h0042, "R10", "held word sent", rx_frm[1], 16'h0042);

    // R12 disable mid-frame
    setup_master(8, 1'b1, 1'b0, 3);
    wr(16'h00FF);
    wait_tr(3);
    tx_en = 1'b0;
    step();
    chk(buf_empty == 1'b1 && tend == 1'b0, "R12", "flags after disable", {buf_empty, tend}, 2);
    chk(sck_out == 1'b1, "R12", "clock at rest after disable", sck_out, 1);
    snap = tr_cnt;
    repeat (20) step();
    chk(tr_cnt == snap, "R12", "no edges after disable", tr_cnt, snap);
    tx_en = 1'b1;

    // R11 slave mode
    run_slave(8, 1'b0, 1'b0, 16'h00B6);
    run_slave(0, 1'b1, 1'b0, 16'hC35A);
    run_slave(11, 1'b0, 1'b1, 16'h05A3);
    run_slave(0, 1'b1, 1'b1, 16'h9E17);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule